// File: doc/BRIEF.md
# Port-Mapped SPI Command Engine

This block is a small SPI master. A host reaches it through eight byte-wide I/O ports that sit at consecutive offsets. Software first stores an opcode, up to three address bytes and one extra outgoing byte in their own ports. It then writes a control byte. That byte picks the SCK rate, gives the outgoing length as a compact two-bit code and gives the number of reply bytes, from zero to three. The engine drives chip select low, shifts the frame out in SPI mode 0 and captures the reply bytes into read ports. While it works it shows busy in bit 7 of the control port.

A second control class opens a page-program frame. The engine sends the opcode and keeps chip select low. Each byte the host then writes on the memory-write strobe is streamed onto the wire. Writing zero to the control port closes the frame.

Top module: `spi_port_engine`

## Requirements
- R1: After reset, chip select (`spi_cs_n`) is high, `spi_sck` is low and a read of offset 0 returns 0x00. At any time, a read of offset 0 returns busy in bit 7 and zero in bits 6:0.
- R2: A write to offset 0 starts a command only when bits 7:4 are 0x4 or 0x5. They open a page frame only when they are 0x2 or 0x3. Any other value of bits 7:4 starts no frame and leaves busy clear.
- R3: Bits 1:0 of the control byte set the outgoing bytes, in wire order. Code 0 sends the opcode only. Code 1 sends the opcode, then offset 7. Code 2 sends the opcode, then offsets 4, 3 and 2. Code 3 sends the opcode, then offsets 4, 3, 2 and 7.
- R4: Bits 3:2 of the control byte give N reply bytes, from 0 to 3. N bytes are clocked after the outgoing bytes with MOSI held at zero. In receive order they land in offsets 5, 6 and 7. When N is less than 3, offset 7 keeps its written value.
- R5: The wire uses SPI mode 0. SCK idles low and MOSI is steady while SCK is high. Bytes go out and come in most significant bit first.
- R6: SCK stays high for FAST_HALF system clocks per bit when control bit 4 is 1, and for SLOW_HALF clocks per bit when it is 0.
- R7: Chip select stays low from the first bit of a frame to its last bit. Between frames it goes high for at least one clock, and SCK never rises while chip select is high.
- R8: While busy is set, writes to offsets 0 to 4 and 7 are ignored.
- R9: In a page frame, the opcode is sent, chip select stays low and busy clears. Each accepted memory-write byte is shifted out. A memory write while busy, or outside a page frame, is ignored. A control write of 0x00 closes the frame.
- R10: Offsets 1 to 4 read back their stored bytes. Offsets 5 and 6 read back reply bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_wr | input | 1 | Port write strobe |
| io_addr | input | 3 | Port offset from the base |
| io_wdata | input | 8 | Port write data |
| io_rdata | output | 8 | Port read data (combinational on io_addr) |
| mem_wr | input | 1 | Memory-write strobe used in a page frame |
| mem_wdata | input | 8 | Byte streamed in a page frame |
| spi_sck | output | 1 | SPI clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The hardest situation to bring about is a port write that lands while a frame is in flight. This covers a new address, a second control byte, or a memory-write strobe during the short load cycle of a page byte. The bench issues these writes right after a control write, while busy is known to be set. It then proves they had no effect through the readback ports and the captured wire bytes. It also issues a back-to-back memory write one clock after an accepted one.

// File: rtl/spe_pkg.sv
package spe_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_SHIFT, ST_PAGE, ST_PLOAD, ST_PSHIFT, ST_FIN, ST_GAP
  } spe_state_t;

  typedef enum logic [1:0] {K_NONE, K_CMD, K_PAGE} ctl_kind_t;

  // class of a control byte from its upper nibble
  function automatic ctl_kind_t decode_kind(input logic [3:0] nib);
    case (nib)
      4'h4, 4'h5: return K_CMD;
      4'h2, 4'h3: return K_PAGE;
      default:    return K_NONE;
    endcase
  endfunction

  // outgoing byte count from the two-bit length code
  function automatic logic [2:0] tx_count(input logic [1:0] code);
    case (code)
      2'd0: return 3'd1;
      2'd1: return 3'd2;
      2'd2: return 3'd4;
      default: return 3'd5;
    endcase
  endfunction

  // byte on the wire at position idx; address ports leave high offset first
  function automatic logic [7:0] pick_tx(input logic [1:0] code, input logic [2:0] idx,
                                         input logic [7:0] op, input logic [7:0] p2,
                                         input logic [7:0] p3, input logic [7:0] p4,
                                         input logic [7:0] p7);
    logic [7:0] b;
    b = 8'h00;
    if (idx == 3'd0) b = op;
    else if (code == 2'd1 && idx == 3'd1) b = p7;
    else if (code[1]) begin
      case (idx)
        3'd1: b = p4;
        3'd2: b = p3;
        3'd3: b = p2;
        3'd4: b = code[0] ? p7 : 8'h00;
        default: b = 8'h00;
      endcase
    end
    return b;
  endfunction

endpackage

// File: rtl/spe_clkgen.sv
module spe_clkgen #(
  parameter int FAST_HALF = 2,
  parameter int SLOW_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic fast,
  output logic tick
);
  localparam int MAXH = (FAST_HALF > SLOW_HALF) ? FAST_HALF : SLOW_HALF;
  localparam int CW   = $clog2(MAXH + 1);
  localparam logic [CW-1:0] FAST_END = CW'(FAST_HALF - 1);
  localparam logic [CW-1:0] SLOW_END = CW'(SLOW_HALF - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] end_w;

  assign end_w = fast ? FAST_END : SLOW_END;
  assign tick  = en && (cnt_q == end_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!en)    cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spe_shifter.sv
module spe_shifter #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [BITS-1:0] tx_byte,
  input  logic            tick,
  input  logic            miso,
  output logic            active,
  output logic            done,
  output logic            sck,
  output logic            mosi,
  output logic [BITS-1:0] rx_byte
);
  localparam int BW = $clog2(BITS);
  localparam logic [BW-1:0] LAST = BW'(BITS - 1);

  logic [BITS-1:0] sr_q;
  logic [BW-1:0]   bit_q;

  assign mosi = sr_q[BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0; bit_q <= '0; active <= 1'b0; done <= 1'b0;
      sck <= 1'b0; rx_byte <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        sr_q <= tx_byte; bit_q <= '0; active <= 1'b1; sck <= 1'b0;
      end else if (active && tick) begin
        if (!sck) begin
          sck     <= 1'b1;
          rx_byte <= {rx_byte[BITS-2:0], miso};
        end else begin
          sck <= 1'b0;
          if (bit_q == LAST) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            bit_q <= bit_q + 1'b1;
            sr_q  <= {sr_q[BITS-2:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/spe_sequencer.sv
module spe_sequencer
  import spe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_val,
  input  logic       mem_wr,
  input  logic [7:0] mem_byte,
  input  logic [7:0] op,
  input  logic [7:0] p2,
  input  logic [7:0] p3,
  input  logic [7:0] p4,
  input  logic [7:0] p7,
  input  logic       sh_done,
  output logic       cs_n,
  output logic       busy,
  output logic       fast,
  output logic       sh_start,
  output logic [7:0] sh_tx,
  output logic       rx_we,
  output logic [1:0] rx_slot
);
  spe_state_t state_q;
  logic [2:0] n_tx_q, idx_q;
  logic [1:0] n_rx_q, code_q;
  logic       pmode_q;
  logic [7:0] pbyte_q;
  logic       last_w;
  logic [2:0] slot_w;
  ctl_kind_t  kind_w;

  assign kind_w   = decode_kind(ctl_val[7:4]);
  assign last_w   = ({1'b0, idx_q} + 4'd1) == ({1'b0, n_tx_q} + {2'b00, n_rx_q});
  assign slot_w   = idx_q - n_tx_q;
  assign rx_slot  = slot_w[1:0];
  assign rx_we    = (state_q == ST_SHIFT) && sh_done && (idx_q >= n_tx_q);
  assign busy     = (state_q != ST_IDLE) && (state_q != ST_PAGE);
  assign sh_start = (state_q == ST_LOAD) || (state_q == ST_PLOAD);
  assign sh_tx    = (state_q == ST_PLOAD) ? pbyte_q
                  : ((idx_q < n_tx_q) ? pick_tx(code_q, idx_q, op, p2, p3, p4, p7) : 8'h00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; cs_n <= 1'b1; fast <= 1'b0; pmode_q <= 1'b0;
      n_tx_q <= 3'd1; n_rx_q <= '0; code_q <= '0; idx_q <= '0; pbyte_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (ctl_wr && kind_w != K_NONE) begin
          fast    <= ctl_val[4];
          code_q  <= ctl_val[1:0];
          idx_q   <= '0;
          cs_n    <= 1'b0;
          pmode_q <= (kind_w == K_PAGE);
          n_tx_q  <= (kind_w == K_PAGE) ? 3'd1 : tx_count(ctl_val[1:0]);
          n_rx_q  <= (kind_w == K_PAGE) ? 2'd0 : ctl_val[3:2];
          state_q <= ST_LOAD;
        end
        ST_LOAD:  state_q <= ST_SHIFT;
        ST_SHIFT: if (sh_done) begin
          if (last_w) state_q <= pmode_q ? ST_PAGE : ST_FIN;
          else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= ST_LOAD;
          end
        end
        ST_PAGE: begin
          if (mem_wr) begin
            pbyte_q <= mem_byte;
            state_q <= ST_PLOAD;
          end else if (ctl_wr && ctl_val == 8'h00) state_q <= ST_FIN;
        end
        ST_PLOAD:  state_q <= ST_PSHIFT;
        ST_PSHIFT: if (sh_done) state_q <= ST_PAGE;
        ST_FIN: begin
          cs_n    <= 1'b1;
          state_q <= ST_GAP;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_port_engine.sv
module spi_port_engine #(
  parameter int FAST_HALF = 2,
  parameter int SLOW_HALF = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       io_wr,
  input  logic [2:0] io_addr,
  input  logic [7:0] io_wdata,
  output logic [7:0] io_rdata,
  input  logic       mem_wr,
  input  logic [7:0] mem_wdata,
  output logic       spi_sck,
  output logic       spi_cs_n,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  logic [7:0] p1_q, p2_q, p3_q, p4_q, p5_q, p6_q, p7_q;
  logic       busy_w, fast_w, tick_w, sh_active_w, sh_done_w, sh_start_w;
  logic       rx_we_w, ctl_wr_w, port_wr_w;
  logic [1:0] rx_slot_w;
  logic [7:0] sh_tx_w, sh_rx_w;
  logic [31:0] bank_view;

  assign port_wr_w = io_wr && !busy_w;
  assign ctl_wr_w  = port_wr_w && (io_addr == 3'd0);
  assign bank_view = {p1_q, p2_q, p3_q, p4_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1_q <= '0; p2_q <= '0; p3_q <= '0; p4_q <= '0;
      p5_q <= '0; p6_q <= '0; p7_q <= '0;
    end else if (rx_we_w) begin
      case (rx_slot_w)
        2'd0:    p5_q <= sh_rx_w;
        2'd1:    p6_q <= sh_rx_w;
        default: p7_q <= sh_rx_w;
      endcase
    end else if (port_wr_w) begin
      case (io_addr)
        3'd1: p1_q <= io_wdata;
        3'd2: p2_q <= io_wdata;
        3'd3: p3_q <= io_wdata;
        3'd4: p4_q <= io_wdata;
        3'd7: p7_q <= io_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (io_addr)
      3'd0: io_rdata = {busy_w, 7'b0};
      3'd1: io_rdata = p1_q;
      3'd2: io_rdata = p2_q;
      3'd3: io_rdata = p3_q;
      3'd4: io_rdata = p4_q;
      3'd5: io_rdata = p5_q;
      3'd6: io_rdata = p6_q;
      default: io_rdata = p7_q;
    endcase
  end

  spe_sequencer seq_i (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr_w), .ctl_val(io_wdata),
    .mem_wr(mem_wr), .mem_byte(mem_wdata), .op(p1_q), .p2(p2_q), .p3(p3_q),
    .p4(p4_q), .p7(p7_q), .sh_done(sh_done_w), .cs_n(spi_cs_n), .busy(busy_w),
    .fast(fast_w), .sh_start(sh_start_w), .sh_tx(sh_tx_w), .rx_we(rx_we_w),
    .rx_slot(rx_slot_w)
  );

  spe_clkgen #(.FAST_HALF(FAST_HALF), .SLOW_HALF(SLOW_HALF)) clk_i (
    .clk(clk), .rst_n(rst_n), .en(sh_active_w), .fast(fast_w), .tick(tick_w)
  );

  spe_shifter #(.BITS(8)) sh_i (
    .clk(clk), .rst_n(rst_n), .start(sh_start_w), .tx_byte(sh_tx_w),
    .tick(tick_w), .miso(spi_miso), .active(sh_active_w), .done(sh_done_w),
    .sck(spi_sck), .mosi(spi_mosi), .rx_byte(sh_rx_w)
  );
endmodule

// File: rtl/spe_checker.sv
module spe_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        io_wr,
  input logic [2:0]  io_addr,
  input logic [31:0] bank_view,
  input logic        sck,
  input logic        cs_n,
  input logic        mosi
);
  // R5: mode 0, clock idles low outside a frame
  a_r5_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  // R5: data held while clock is high
  a_r5_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));

  // R7: no rising clock edge without chip select
  a_r7_sck_rise_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> !cs_n);

  // R7: chip select released for at least one clock
  a_r7_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> cs_n);

  // R1: a frame opening shows busy
  a_r1_busy_on_open: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> busy);

  // R8: port writes during busy leave the stored bytes alone
  a_r8_ignore_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && io_wr && io_addr != 3'd0) |=> $stable(bank_view));
endmodule

bind spi_port_engine spe_checker chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy_w), .io_wr(io_wr), .io_addr(io_addr),
  .bank_view(bank_view), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi)
);

// File: tb/spi_port_engine_tb_top.sv
module spi_port_engine_tb_top;
  localparam int FH = 2;
  localparam int SH = 4;

  logic clk = 1'b0, rst_n = 1'b0, io_wr = 1'b0, mem_wr = 1'b0;
  logic [2:0] io_addr = '0;
  logic [7:0] io_wdata = '0, mem_wdata = '0, io_rdata;
  logic spi_sck, spi_cs_n, spi_mosi, spi_miso;

  int checks = 0, errors = 0;
  int seed = 0;
  int bitcnt = 0;
  int frames = 0;
  int hicnt = 0;
  logic [7:0] cap [0:7];

  always #10 clk = ~clk;

  spi_port_engine #(.FAST_HALF(FH), .SLOW_HALF(SH)) dut_i (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .mem_wr(mem_wr), .mem_wdata(mem_wdata), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  function automatic logic [7:0] resp(input int k, input int s);
    return 8'(8'h5A ^ (k * 8'd29) ^ (s * 8'd7));
  endfunction

  // device model: reply byte k of the frame, most significant bit first
  assign spi_miso = resp(bitcnt / 8, seed) >> (7 - (bitcnt % 8));

  always @(posedge spi_sck or posedge spi_cs_n) begin
    if (spi_cs_n) bitcnt = 0;
    else begin
      cap[bitcnt / 8] = {cap[bitcnt / 8][6:0], spi_mosi};
      bitcnt = bitcnt + 1;
    end
  end
  always @(negedge spi_cs_n) frames = frames + 1;
  always @(negedge clk) if (!spi_cs_n && spi_sck) hicnt = hicnt + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic io_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); io_addr = a; #2; d = io_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] st;
    int n;
    n = 0;
    io_read(3'd0, st);
    while (st[7] && n < 5000) begin io_read(3'd0, st); n++; end
    if (n >= 5000) check(1'b0, "watchdog busy", n, 0);
  endtask

  // wire byte i expected for length code c
  function automatic logic [7:0] exp_tx(input int c, input int i, input logic [7:0] b1,
      input logic [7:0] b2, input logic [7:0] b3, input logic [7:0] b4, input logic [7:0] b7);
    logic [7:0] seq [0:4];
    seq[0] = b1;
    if (c == 1) seq[1] = b7;
    else begin seq[1] = b4; seq[2] = b3; seq[3] = b2; seq[4] = b7; end
    return seq[i];
  endfunction

  initial begin
    #(20 * 190000);
    check(1'b0, "watchdog global", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int ntx, f0;
    logic [7:0] b1, b2, b3, b4, b7;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(spi_cs_n === 1'b1, "R1 cs_n reset", spi_cs_n, 1);
    check(spi_sck === 1'b0, "R1 sck reset", spi_sck, 0);
    rst_n = 1'b1;
    io_read(3'd0, rd);
    check(rd === 8'h00, "R1 status reset", rd, 0);

    // sweep every length code, reply count and rate
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        for (int f = 0; f < 2; f++) begin
          seed = c * 8 + r * 2 + f;
          b1 = 8'(8'h11 * (seed + 1)); b2 = 8'(seed * 13 + 3); b3 = 8'(seed * 5 + 128);
          b4 = 8'(8'hC3 ^ seed); b7 = 8'(8'h3C + seed);
          io_write(3'd1, b1); io_write(3'd2, b2); io_write(3'd3, b3);
          io_write(3'd4, b4); io_write(3'd7, b7);
          io_read(3'd4, rd);
          check(rd === b4, "R10 readback offset 4", rd, b4);
          ntx = (c == 0) ? 1 : (c == 1) ? 2 : (c == 2) ? 4 : 5;
          hicnt = 0; f0 = frames;
          io_write(3'd0, 8'((f ? 8'h50 : 8'h40) | (r << 2) | c));
          io_read(3'd0, rd);
          check(rd === 8'h80, "R1 busy shown", rd, 8'h80);
          wait_idle();
          check(frames == f0 + 1, "R7 one frame", frames - f0, 1);
          check(spi_cs_n === 1'b1, "R7 cs released", spi_cs_n, 1);
          check(hicnt == 8 * (ntx + r) * (f ? FH : SH), "R6 sck high time", hicnt,
                8 * (ntx + r) * (f ? FH : SH));
          for (int i = 0; i < ntx; i++)
            check(cap[i] === exp_tx(c, i, b1, b2, b3, b4, b7), "R3 R5 wire byte",
                  cap[i], exp_tx(c, i, b1, b2, b3, b4, b7));
          for (int j = 0; j < r; j++) begin
            check(cap[ntx + j] === 8'h00, "R4 mosi zero in reply", cap[ntx + j], 0);
            io_read(3'(5 + j), rd);
            check(rd === resp(ntx + j, seed), "R4 reply byte", rd, resp(ntx + j, seed));
          end
          if (r < 3) begin
            io_read(3'd7, rd);
            check(rd === b7, "R4 offset 7 kept", rd, b7);
          end
        end

    // R8: writes while busy are ignored
    seed = 40;
    io_write(3'd1, 8'h9F); io_write(3'd2, 8'h01); io_write(3'd3, 8'h02);
    io_write(3'd4, 8'h03); io_write(3'd7, 8'h04);
    f0 = frames;
    io_write(3'd0, 8'h43);
    io_write(3'd1, 8'hEE); io_write(3'd4, 8'hDD); io_write(3'd7, 8'hCC);
    io_write(3'd0, 8'h5F);
    wait_idle();
    io_read(3'd1, rd); check(rd === 8'h9F, "R8 offset 1 kept", rd, 8'h9F);
    io_read(3'd4, rd); check(rd === 8'h03, "R8 offset 4 kept", rd, 8'h03);
    io_read(3'd7, rd); check(rd === 8'h04, "R8 offset 7 kept", rd, 8'h04);
    check(cap[4] === 8'h04, "R8 wire data byte", cap[4], 8'h04);
    check(frames == f0 + 1, "R8 control ignored", frames - f0, 1);

    // R2: other upper nibbles start nothing
    for (int n = 0; n < 16; n++) begin
      if (n >= 2 && n <= 5) continue;
      f0 = frames;
      io_write(3'd0, 8'(n << 4));
      repeat (3) @(negedge clk);
      io_read(3'd0, rd);
      check(rd === 8'h00 && frames == f0, "R2 nibble ignored", n, 0);
    end

    // R9: memory write outside a page frame
    f0 = frames;
    @(negedge clk); mem_wdata = 8'h77; mem_wr = 1'b1; @(negedge clk); mem_wr = 1'b0;
    repeat (3) @(negedge clk);
    check(frames == f0 && spi_cs_n === 1'b1, "R9 stray mem write", frames - f0, 0);

    // R9: page frame at both rates
    for (int f = 0; f < 2; f++) begin
      io_write(3'd1, 8'h02);
      f0 = frames;
      io_write(3'd0, f ? 8'h30 : 8'h20);
      wait_idle();
      check(spi_cs_n === 1'b0, "R9 cs held in page", spi_cs_n, 0);
      for (int k = 0; k < 3; k++) begin
        @(negedge clk); mem_wdata = 8'(8'hA0 + k + f * 16); mem_wr = 1'b1;
        @(negedge clk); mem_wdata = 8'h00;
        @(negedge clk); mem_wr = 1'b0;
        wait_idle();
      end
      io_write(3'd0, 8'h00);
      wait_idle();
      check(spi_cs_n === 1'b1, "R9 frame closed", spi_cs_n, 1);
      check(frames == f0 + 1, "R9 single frame", frames - f0, 1);
      check(cap[0] === 8'h02, "R9 opcode first", cap[0], 8'h02);
      for (int k = 0; k < 3; k++)
        check(cap[k + 1] === 8'(8'hA0 + k + f * 16), "R9 streamed byte", cap[k + 1],
              8'(8'hA0 + k + f * 16));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule